// File: doc/BRIEF.md
# Configurable Registered Address Buffer

This block is the clocked register that sits on a memory module's command and address bus. It captures the incoming bus on the rising clock edge and drives the registered copy out to the memory devices. Two static strap inputs select its shape. In wide mode it carries 25 lanes, each driving one output. In split mode it carries 14 lanes, each driving two outputs. In split mode a second strap chooses which 14 input lanes are used.

Two active-low chip selects gate the data register. When neither select is asserted, the data outputs keep their value, which saves switching power on the module. The chip-select levels are registered on every edge and passed downstream. An asynchronous active-low reset clears every register bit. It forces all outputs low at once, without waiting for a clock edge. The straps are meant to be tied off, and may only change while reset is held.

Top module: `addr_regbuf`

## Requirements
- R1: With `cfg_split` low (wide mode), on each rising clock edge where at least one chip select is low, `q_out[i]` takes `d_in[i]` for every i from 0 to 24.
- R2: In wide mode, output lanes `q_out[27:25]` stay 0 at all times.
- R3: With `cfg_split` high and `cfg_half` low, a loading edge captures `d_in[13:0]`. Both `q_out[13:0]` and `q_out[27:14]` then show that captured value.
- R4: With `cfg_split` high and `cfg_half` high, a loading edge captures `d_in[24:11]`. Both `q_out[13:0]` and `q_out[27:14]` then show that captured value.
- R5: On an edge where both `dcs_n` and `csr_n` are high, the data register keeps its contents and `q_out` does not change. An edge with only one select low loads normally.
- R6: `q_dcs_n` and `q_csr_n` take the values of `dcs_n` and `csr_n` on every rising edge, whatever the select state.
- R7: While `rst_n` is low, `q_out`, `q_dcs_n` and `q_csr_n` are all 0. This takes effect when reset falls, even in mid-cycle, and clock edges during reset do not change it.
- R8: After `rst_n` rises, with the data inputs and selects held low, every output stays 0 on every following edge.
- R9: In split mode, input lanes outside the selected 14 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_split | input | 1 | Strap: 0 selects 25x1 lanes, 1 selects 14x2 lanes |
| cfg_half | input | 1 | Strap in split mode: 0 uses inputs 13..0, 1 uses inputs 24..11 |
| dcs_n | input | 1 | Chip select, active low |
| csr_n | input | 1 | Second chip select, active low |
| d_in | input | 25 | Command/address inputs |
| q_out | output | 28 | Registered data outputs |
| q_dcs_n | output | 1 | Registered copy of `dcs_n` |
| q_csr_n | output | 1 | Registered copy of `csr_n` |

## Verification
The bench brings up each of the three strap settings from reset and checks them against a lane map. A swapped lane map or the wrong half selection would show up as mismatched lanes, and so would pads that float instead of staying 0. Hold checks drive new data with both selects high, and then with each select alone. This exposes a register that loads regardless of selection, or one that needs both selects low. Reset is pulled low a nanosecond after an edge and checked before the next edge, which catches a synchronous reset. Ignored-lane tests toggle the unused inputs in split mode and look for any movement on the outputs.

// File: rtl/addr_regbuf.sv
module addr_regbuf #(
  parameter int WIDE_W  = 25,
  parameter int SPLIT_W = 14
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_split,
  input  logic                   cfg_half,
  input  logic                   dcs_n,
  input  logic                   csr_n,
  input  logic [WIDE_W-1:0]      d_in,
  output logic [2*SPLIT_W-1:0]   q_out,
  output logic                   q_dcs_n,
  output logic                   q_csr_n
);
  localparam int OUT_W = 2 * SPLIT_W;
  localparam int B_LO  = WIDE_W - SPLIT_W;
  localparam int PAD_W = OUT_W - WIDE_W;

  logic [WIDE_W-1:0]  held;
  logic [SPLIT_W-1:0] lane_pick;
  logic               load;

  assign load = !dcs_n || !csr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held    <= '0;
      q_dcs_n <= 1'b0;
      q_csr_n <= 1'b0;
    end else begin
      if (load) held <= d_in;
      q_dcs_n <= dcs_n;
      q_csr_n <= csr_n;
    end
  end

  assign lane_pick = cfg_half ? held[WIDE_W-1:B_LO] : held[SPLIT_W-1:0];
  assign q_out     = cfg_split ? {lane_pick, lane_pick} : {{PAD_W{1'b0}}, held};

  // R1
  wide_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_split && load) |=> q_out[WIDE_W-1:0] == $past(d_in));

  // R2
  wide_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_split |-> q_out[OUT_W-1:WIDE_W] == '0);

  // R3
  split_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_split && !cfg_half && load) |=>
      (q_out[SPLIT_W-1:0] == $past(d_in[SPLIT_W-1:0]) &&
       q_out[OUT_W-1:SPLIT_W] == $past(d_in[SPLIT_W-1:0])));

  // R4
  split_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_split && cfg_half && load) |=>
      (q_out[SPLIT_W-1:0] == $past(d_in[WIDE_W-1:B_LO]) &&
       q_out[OUT_W-1:SPLIT_W] == $past(d_in[WIDE_W-1:B_LO])));

  // R5
  deselect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dcs_n && csr_n) |=> q_out == $past(q_out));

  // R6
  cs_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q_dcs_n == $past(dcs_n) && q_csr_n == $past(csr_n)));

  // R7
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |-> (q_out == '0 && !q_dcs_n && !q_csr_n));
endmodule

// File: tb/addr_regbuf_test.sv
`timescale 1ns/1ps
module addr_regbuf_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_split = 1'b0;
  logic        cfg_half = 1'b0;
  logic        dcs_n = 1'b1;
  logic        csr_n = 1'b1;
  logic [24:0] d_in = '0;
  logic [27:0] q_out;
  logic        q_dcs_n, q_csr_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [24:0] m_reg;
  logic        m_dcs, m_csr;

  addr_regbuf uut (
    .clk(clk), .rst_n(rst_n), .cfg_split(cfg_split), .cfg_half(cfg_half),
    .dcs_n(dcs_n), .csr_n(csr_n), .d_in(d_in),
    .q_out(q_out), .q_dcs_n(q_dcs_n), .q_csr_n(q_csr_n)
  );

  always #2 clk = ~clk;

  function automatic logic [27:0] map_out(input logic [24:0] r, input logic s, input logic h);
    logic [13:0] p;
    if (!s) return {3'b000, r};
    p = h ? r[24:11] : r[13:0];
    return {p, p};
  endfunction

  task automatic check(input bit ok, input string req, input logic [27:0] act, input logic [27:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    logic [27:0] e;
    e = map_out(m_reg, cfg_split, cfg_half);
    check(q_out === e, req, q_out, e);
    check({q_dcs_n, q_csr_n} === {m_dcs, m_csr}, {req, " cs"},
          {26'd0, q_dcs_n, q_csr_n}, {26'd0, m_dcs, m_csr});
  endtask

  // called at a negedge; returns at the following negedge
  task automatic step(input logic [24:0] d, input logic a, input logic b);
    d_in = d; dcs_n = a; csr_n = b;
    @(posedge clk);
    if (!a || !b) m_reg = d;
    m_dcs = a; m_csr = b;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic s, input logic h);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_split = s; cfg_half = h;
    d_in = '0; dcs_n = 1'b0; csr_n = 1'b0;
    m_reg = '0; m_dcs = 1'b0; m_csr = 1'b0;
    repeat (2) @(negedge clk);
    check_all("R7 reset");
    rst_n = 1'b1;
    // R8: inputs low after release, outputs must stay low
    for (int i = 0; i < 3; i++) begin
      step('0, 1'b0, 1'b0);
      check(q_out === 28'd0 && !q_dcs_n && !q_csr_n, "R8 release", q_out, 28'd0);
    end
  endtask

  task automatic test_wide();
    logic [24:0] pats [4];
    pats[0] = 25'h1FFFFFF; pats[1] = 25'h0AAAAAA; pats[2] = 25'h1555555; pats[3] = 25'h1000001;
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      step(pats[i], 1'b0, 1'b1);
      check_all("R1 wide lanes");
      check(q_out[27:25] === 3'b000, "R2 pad lanes", q_out, {3'b000, q_out[24:0]});
    end
    for (int i = 0; i < 25; i++) begin
      step(25'd1 << i, 1'b0, 1'b0);
      check_all("R1 walking one");
    end
  endtask

  task automatic test_split_a();
    logic [27:0] snap;
    do_reset(1'b1, 1'b0);
    step(25'h0003A5C, 1'b0, 1'b1);
    check_all("R3 half A");
    step(25'h1FFC000 | 25'h0001234, 1'b1, 1'b0);
    check_all("R3 half A pattern");
    snap = q_out;
    step(25'h0AAC000 | 25'h0001234, 1'b0, 1'b0);
    check(q_out === snap, "R9 upper lanes ignored", q_out, snap);
    check_all("R9 half A model");
  endtask

  task automatic test_split_b();
    logic [27:0] snap;
    do_reset(1'b1, 1'b1);
    step(25'h1ABC800, 1'b0, 1'b1);
    check_all("R4 half B");
    step(25'h0F0F7FF, 1'b1, 1'b0);
    check_all("R4 half B pattern");
    snap = q_out;
    step(25'h0F0F000, 1'b0, 1'b0);
    check(q_out === snap, "R9 lower lanes ignored", q_out, snap);
    check_all("R9 half B model");
  endtask

  task automatic test_hold();
    logic [27:0] snap;
    do_reset(1'b0, 1'b0);
    step(25'h0123456, 1'b0, 1'b0);
    snap = q_out;
    step(25'h1FEDCBA, 1'b1, 1'b1);
    check(q_out === snap, "R5 deselected hold", q_out, snap);
    check_all("R6 cs pass while held");
    step(25'h0000F0F, 1'b1, 1'b1);
    check(q_out === snap, "R5 second hold", q_out, snap);
    step(25'h1111111, 1'b1, 1'b0);
    check_all("R5 csr only loads");
    step(25'h0222222, 1'b0, 1'b1);
    check_all("R5 dcs only loads");
    check(q_dcs_n === 1'b0 && q_csr_n === 1'b1, "R6 cs registered",
          {26'd0, q_dcs_n, q_csr_n}, 28'd1);
  endtask

  task automatic test_mid_reset();
    do_reset(1'b1, 1'b1);
    step(25'h1FFFFFF, 1'b1, 1'b0);
    @(posedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check(q_out === 28'd0, "R7 async clear", q_out, 28'd0);
    check(!q_dcs_n && !q_csr_n, "R7 cs clear", {26'd0, q_dcs_n, q_csr_n}, 28'd0);
    d_in = 25'h1FFFFFF; dcs_n = 1'b0; csr_n = 1'b0;
    repeat (3) @(negedge clk);
    check(q_out === 28'd0 && !q_dcs_n && !q_csr_n, "R7 held in reset", q_out, 28'd0);
    m_reg = '0; m_dcs = 1'b0; m_csr = 1'b0;
    d_in = '0;
    rst_n = 1'b1;
    for (int i = 0; i < 2; i++) begin
      step('0, 1'b0, 1'b0);
      check(q_out === 28'd0, "R8 after mid reset", q_out, 28'd0);
    end
  endtask

  initial begin
    m_reg = '0; m_dcs = 1'b0; m_csr = 1'b0;
    repeat (2) @(negedge clk);
    check(q_out === 28'd0 && !q_dcs_n && !q_csr_n, "R7 power-up", q_out, 28'd0);
    test_wide();
    test_split_a();
    test_split_b();
    test_hold();
    test_mid_reset();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule